// File: doc/BRIEF.md
# Frequency-Count Successive Approximation Calibrator

This engine trims an 8-bit calibration DAC code so that the frequency swing produced by a modulation path matches a target. It works purely by counting. A reference-tick counter sets a measurement window of fixed length, and a feedback-tick counter measures the oscillator inside that window. A start pulse begins a run. The engine first takes one window with the DAC code at zero, counting every feedback tick, and stores that count as the centre baseline.

It then runs one trial window per DAC bit, from the most significant bit down. In a trial window feedback ticks are counted only while the modulation high-phase flag is set, so the window spans several half-periods of the triangular waveform. The baseline is subtracted from the trial count, and the result is compared with the expected count for the chosen depth. The sign of that difference decides whether the trial bit stays set.

After the last decision the engine raises done. Pass is raised with it only if no fault was flagged and no counter saturated during the run. Both the reference and feedback ticks arrive as one-cycle enables in the single clock domain.

Top module: `fmcal_sar`

## Requirements
- R1: After reset `dac_code_o` is 0, and `done_o` and `pass_o` are both 0.
- R2: A cycle with `start_i`=1 clears done and pass and sets the code to 0. The following window is the centre window, which ends when the REF_TERM-th reference tick is counted. In the centre window the code stays 0 and every feedback tick counts, whatever `mod_high_i` is.
- R3: In the first cycle after the centre window ends, the code is 8'b1000_0000, with only the top bit on trial.
- R4: In a trial window, a feedback tick is counted only in a cycle where `mod_high_i`=1.
- R5: At the end of each trial window the delta is the trial count minus the stored centre count. The trial bit is kept when `expect_i` minus the delta is zero or more, and cleared otherwise. The next lower bit is then set for trial. The centre count is kept for all eight decisions. When the feedback count rises monotonically with the code, the final code is the largest code whose delta does not exceed `expect_i`.
- R6: Exactly CODE_W decisions are made. `done_o` rises on the clock edge that ends the last trial window, which is (CODE_W+1)·REF_TERM reference ticks after start. Before that edge it stays 0.
- R7: `pass_o` is 1 only together with `done_o`, and only when the run saw no fault and no overflow.
- R8: If `fault_i` is 1 in any cycle of a run, the run finishes with `pass_o`=0.
- R9: A feedback counter that is full and receives another tick holds its value and flags an error, and that run finishes with `pass_o`=0.
- R10: A start pulse in the middle of a run, or in the same cycle as the final decision, wins. In the next cycle done is 0 and the code is 0, and a complete new run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request that begins a calibration run |
| ref_tick_i | input | 1 | Reference clock event enable |
| fb_tick_i | input | 1 | Feedback clock event enable |
| mod_high_i | input | 1 | High phase of the triangular modulation |
| expect_i | input | CNT_W | Expected delta count for the selected depth |
| fault_i | input | 1 | Error indication during a run |
| dac_code_o | output | CODE_W | Calibration DAC code (trial code while running) |
| done_o | output | 1 | Run complete |
| pass_o | output | 1 | Run complete with no error |

## Verification
The function most likely to collide with another is the restart path. A new start can land in the same cycle as the final decision, which would otherwise set done and load pass. To provoke this, the bench raises start in the very last cycle of the last trial window. In the next cycle it requires done to be 0 and the code to be 0, and it then requires a complete new run to give the right result. A second collision is a fault pulse inside a trial window while the decision logic is running. The bench judges this by requiring a correct code together with pass held at 0.

// File: rtl/fmcal_pkg.sv
package fmcal_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CENTER = 2'd1,
      PH_TRIAL  = 2'd2
   } cal_phase_t;
endpackage

// File: rtl/fmcal_evt_counter.sv
module fmcal_evt_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] sum_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2) begin : g_bad_width
      $error("fmcal_evt_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_max;

   assign at_max = (cnt_q == CNT_MAX);
   assign ovf_o  = inc_i & at_max;
   assign sum_o  = (inc_i && !at_max) ? cnt_q + 1'b1 : cnt_q;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= sum_o;
   end

   AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_i) |=> (cnt_o == CNT_MAX)); // R9
endmodule

// File: rtl/fmcal_sar_reg.sv
module fmcal_sar_reg #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              seed_i,
   input  logic              decide_i,
   input  logic              keep_i,
   output logic [CODE_W-1:0] code_o,
   output logic              last_o
);
   localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};

   if (CODE_W < 2) begin : g_bad_width
      $error("fmcal_sar_reg: CODE_W must be at least 2");
   end

   logic [CODE_W-1:0] code_q, probe_q, probe_down, code_after;

   assign probe_down = probe_q >> 1;

   for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      assign code_after[i] = probe_q[i] ? keep_i : (code_q[i] | probe_down[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         probe_q <= '0;
      end else if (clear_i) begin
         code_q  <= '0;
         probe_q <= '0;
      end else if (seed_i) begin
         code_q  <= TOP_BIT;
         probe_q <= TOP_BIT;
      end else if (decide_i) begin
         code_q  <= code_after;
         probe_q <= probe_down;
      end
   end

   assign code_o = code_q;
   assign last_o = probe_q[0];

   AST_PROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(probe_q)); // R5
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !seed_i && !decide_i) |=> $stable(code_o)); // R5
endmodule

// File: rtl/fmcal_sar.sv
module fmcal_sar #(
   parameter int CODE_W   = 8,
   parameter int CNT_W    = 12,
   parameter int REF_TERM = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ref_tick_i,
   input  logic              fb_tick_i,
   input  logic              mod_high_i,
   input  logic [CNT_W-1:0]  expect_i,
   input  logic              fault_i,
   output logic [CODE_W-1:0] dac_code_o,
   output logic              done_o,
   output logic              pass_o
);
   import fmcal_pkg::*;

   localparam int REF_W = $clog2(REF_TERM + 1);
   localparam int ERR_W = CNT_W + 2;
   localparam logic [REF_W-1:0] REF_END = REF_W'(REF_TERM);

   if (REF_TERM < 2) begin : g_bad_term
      $error("fmcal_sar: REF_TERM must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("fmcal_sar: CNT_W must be at least 2");
   end

   cal_phase_t        phase_q;
   logic [CNT_W-1:0]  base_q;
   logic              err_q, done_q, pass_q;

   logic              active, win_end, cnt_clr;
   logic              ref_inc, fb_inc, fb_gate;
   logic [REF_W-1:0]  ref_cnt, ref_sum;
   logic [CNT_W-1:0]  fb_cnt, fb_sum;
   logic              ref_ovf, fb_ovf;
   logic signed [ERR_W-1:0] delta, gap;
   logic              keep, seed, decide, last;

   assign active  = (phase_q != PH_IDLE);
   assign ref_inc = active && ref_tick_i;
   assign win_end = ref_inc && (ref_sum == REF_END);
   assign fb_gate = (phase_q == PH_CENTER) ? 1'b1 : mod_high_i;
   assign fb_inc  = active && fb_tick_i && fb_gate;
   assign cnt_clr = start_i || win_end || !active;

   fmcal_evt_counter #(.CNT_W(REF_W)) u_ref_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(ref_inc),
      .cnt_o(ref_cnt), .sum_o(ref_sum), .ovf_o(ref_ovf)
   );

   fmcal_evt_counter #(.CNT_W(CNT_W)) u_fb_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(fb_inc),
      .cnt_o(fb_cnt), .sum_o(fb_sum), .ovf_o(fb_ovf)
   );

   assign delta = $signed({2'b00, fb_sum}) - $signed({2'b00, base_q});
   assign gap   = $signed({2'b00, expect_i}) - delta;
   assign keep  = ~gap[ERR_W-1];

   assign seed   = !start_i && (phase_q == PH_CENTER) && win_end;
   assign decide = !start_i && (phase_q == PH_TRIAL) && win_end;

   fmcal_sar_reg #(.CODE_W(CODE_W)) u_sar (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .seed_i(seed),
      .decide_i(decide), .keep_i(keep), .code_o(dac_code_o), .last_o(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         base_q  <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
      end else if (start_i) begin
         phase_q <= PH_CENTER;
         base_q  <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         if (active && (fault_i || fb_ovf || ref_ovf)) err_q <= 1'b1;
         if (seed) begin
            base_q  <= fb_sum;
            phase_q <= PH_TRIAL;
         end
         if (decide && last) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
            pass_q  <= !(err_q || fault_i || fb_ovf || ref_ovf);
         end
      end
   end

   assign done_o = done_q;
   assign pass_o = pass_q;

   AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o); // R7
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && dac_code_o == '0)); // R10
   AST_CENTER_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CENTER) |-> (dac_code_o == '0)); // R2
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_TRIAL && !mod_high_i && !cnt_clr) |=> $stable(fb_cnt)); // R4
   AST_FAULT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && fault_i && !start_i) |=> !pass_o); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (phase_q == PH_IDLE)); // R6
   AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cnt < REF_END); // R6
endmodule

// File: tb/fmcal_sar_bench.sv
`timescale 1ns/1ps
module fmcal_sar_bench;
   localparam int CODE_W = 8;
   localparam int CNT_W  = 12;
   localparam int W      = 256;
   localparam int NV     = 7;

   // vector table: centre count, slope shift, expected delta
   localparam int VB [NV] = '{0, 5, 1, 64, 0, 33, 1};
   localparam int VS [NV] = '{2, 2, 1, 2, 1, 2, 1};
   localparam int VE [NV] = '{0, 10, 40, 63, 127, 17, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, ref_tick_i = 1'b1, fb_tick_i = 1'b0;
   logic mod_high_i = 1'b0, fault_i = 1'b0;
   logic [CNT_W-1:0] exp_val = '0;
   logic [CODE_W-1:0] code_m, code_s;
   logic done_m, pass_m, done_s, pass_s;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   int code_w0, code_w1, done_mid;

   always #2.5 clk = ~clk;

   fmcal_sar #(.CODE_W(CODE_W), .CNT_W(CNT_W), .REF_TERM(W)) u_fmcal_sar (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_tick_i(ref_tick_i),
      .fb_tick_i(fb_tick_i), .mod_high_i(mod_high_i), .expect_i(exp_val),
      .fault_i(fault_i), .dac_code_o(code_m), .done_o(done_m), .pass_o(pass_m)
   );

   fmcal_sar #(.CODE_W(CODE_W), .CNT_W(6), .REF_TERM(W)) u_fmcal_sar_small (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_tick_i(ref_tick_i),
      .fb_tick_i(fb_tick_i), .mod_high_i(mod_high_i), .expect_i(exp_val[5:0]),
      .fault_i(fault_i), .dac_code_o(code_s), .done_o(done_s), .pass_o(pass_s)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, expv);
      end
   endtask

   function automatic int model_code(input int sh, input int e);
      int best = 0;
      for (int c = 0; c < (1 << CODE_W); c++)
         if ((c >> sh) <= e) best = c;
      return best;
   endfunction

   // called at a negedge; drives a run of n_win windows
   task automatic run_cal(input int b, input int sh, input int e,
                          input int fault_w, input int n_win, input bit clash);
      exp_val = CNT_W'(e);
      start_i = 1'b1;
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      code_w0 = -1; code_w1 = -1; done_mid = -1;
      for (int w = 0; w < n_win; w++) begin
         for (int k = 0; k < W; k++) begin
            int h, f;
            if (k == 0 && w == 0) code_w0 = int'(code_m);
            if (k == 0 && w == 1) code_w1 = int'(code_m);
            if (k == 0 && w == CODE_W) done_mid = int'(done_m);
            mod_high_i = ((k % 16) < 8);
            h = (k / 16) * 8 + (k % 8);
            f = int'(code_m) >> sh;
            if (w == 0) fb_tick_i = (k < b);
            else        fb_tick_i = mod_high_i ? (h < b + f) : 1'b1;
            fault_i = (w == fault_w && k == 5);
            start_i = clash && (w == n_win - 1) && (k == W - 1);
            @(posedge clk); @(negedge clk);
         end
      end
      fault_i = 1'b0; fb_tick_i = 1'b0; start_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int expc;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(code_m == 0, "R1 code", int'(code_m), 0);
      chk(done_m == 0, "R1 done", int'(done_m), 0);
      chk(pass_m == 0, "R1 pass", int'(pass_m), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         expc = model_code(VS[v], VE[v]);
         run_cal(VB[v], VS[v], VE[v], -1, CODE_W + 1, 1'b0);
         chk(code_w0 == 0, "R2 centre code", code_w0, 0);
         chk(code_w1 == 128, "R3 first trial", code_w1, 128);
         chk(done_mid == 0, "R6 done early", done_mid, 0);
         chk(done_m == 1, "R6 done", int'(done_m), 1);
         chk(int'(code_m) == expc, "R5 R4 code", int'(code_m), expc);
         chk(pass_m == 1, "R7 pass", int'(pass_m), 1);
         if (v == 0) begin
            chk(pass_s == 1 && int'(code_s) == expc, "R9 small ok", int'(code_s), expc);
         end
         if (v == 3) begin
            chk(done_s == 1, "R9 small done", int'(done_s), 1);
            chk(pass_s == 0, "R9 overflow pass", int'(pass_s), 0);
         end
      end

      // R8 fault during trial window 3
      expc = model_code(2, 10);
      run_cal(5, 2, 10, 3, CODE_W + 1, 1'b0);
      chk(done_m == 1, "R8 done", int'(done_m), 1);
      chk(pass_m == 0, "R8 pass", int'(pass_m), 0);
      chk(int'(code_m) == expc, "R8 code", int'(code_m), expc);

      // R10 restart mid-run, then a full run
      run_cal(1, 1, 40, -1, 4, 1'b0);
      expc = model_code(2, 17);
      run_cal(33, 2, 17, -1, CODE_W + 1, 1'b0);
      chk(code_w0 == 0, "R10 restart code", code_w0, 0);
      chk(int'(code_m) == expc && done_m == 1, "R10 restart result", int'(code_m), expc);

      // R10 start coincident with final decision
      run_cal(5, 2, 10, -1, CODE_W + 1, 1'b1);
      chk(done_m == 0, "R10 clash done", int'(done_m), 0);
      chk(code_m == 0, "R10 clash code", int'(code_m), 0);
      expc = model_code(1, 127);
      run_cal(0, 1, 127, -1, CODE_W + 1, 1'b0);
      chk(int'(code_m) == expc && pass_m == 1, "R10 after clash", int'(code_m), expc);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule